// File: doc/BRIEF.md
# Banked Nibble Real-Time Clock

This block is a calendar clock that a bus master controls through sixteen 4-bit locations. Three locations at the top of the map are control registers and can always be reached. The thirteen below them are shared by four banks, and a field in the mode register chooses which bank they show. The first bank holds the running time and date in BCD. The second holds alarm settings, the 12/24-hour choice and a two-bit leap-year phase. The third and fourth are plain nibble storage.

Timekeeping comes from an input clock enable. Every `SUB_DIV` enables make one sixteenth of a second, and sixteen sixteenths make one second (`TICKS_PER_SEC = 16*SUB_DIV`). Each second advances the calendar with BCD carries through minutes, hours, weekday, day, month and year. Software clears the timer-enable bit to freeze the counters while it reads or loads them. A second that falls due during the freeze is kept and applied when the timer restarts.

Top module: `nibble_rtc`

## Requirements
- R1: Writes use only `wdata[3:0]`. `rdata` returns the addressed nibble in bits [3:0] and zero in all higher bits.
- R2: Address 0xD is the mode register: bits [1:0] pick the bank (0 time, 1 configuration, 2 and 3 storage), bit 2 is alarm enable and bit 3 is timer enable. It resets to 0. Addresses 0xD, 0xE and 0xF read and write the same registers whatever bank is selected.
- R3: In bank 0, addresses 0 to 12 are: second ones, second tens, minute ones, minute tens, hour ones, hour tens, weekday (0 to 6), day ones, day tens, month ones, month tens, year ones, year tens. After reset the clock reads 00:00:00, weekday 0, day 01, month 01, year 00.
- R4: In bank 1, addresses 2 to 8 store seven alarm nibbles that read back as written. Address 0xA bit 0 selects 24-hour mode when 1 and resets to 1. Address 0xB bits [1:0] are the leap-year phase and reset to 0. Addresses 0, 1, 9 and 0xC read 0, and writes to them have no effect.
- R5: Banks 2 and 3 each provide 13 independent nibbles at addresses 0 to 12.
- R6: With the timer enabled, every `TICKS_PER_SEC` cycles with `tick_en` high advance the time by one second. Seconds and minutes wrap 59 to 00, 24-hour time wraps 23 to 00, the weekday wraps 6 to 0, months run 1 to 12 and the year wraps 99 to 00.
- R7: Day of month wraps after 30 days in months 4, 6, 9 and 11 and after 31 days in the other months except February. February has 29 days when the leap-year phase is 0 and 28 days otherwise. The phase increments modulo 4 at each move from 31 December to 1 January.
- R8: In 12-hour mode, the hour-tens nibble holds the PM flag in bit 1 and the tens digit in bit 0. Hours run 12, 1, ..., 11. PM toggles on the move from 11 to 12, and the date advances only when PM goes from 1 to 0.
- R9: While timer enable is 0, the time registers change only through writes. One second that falls due during this time is held, and exactly one second is applied when timer enable returns to 1, however long the pause lasted.
- R10: A write to 0xF with bit 0 set clears the seven alarm nibbles. A write with bit 1 set restarts the sub-second divider and drops any held second, so the next second needs a full `TICKS_PER_SEC` enables. Bits 0 and 1 read back as 0. Bits 2 and 3 are stored and read back.
- R11: When 0xF bit 2 is set, `pulse_16hz` is high for one cycle at each sixteenth-second step. When 0xF bit 3 is set, `pulse_1hz` is high for one cycle at each second step. When its bit is clear, each output stays low.
- R12: Address 0xE stores a 4-bit test nibble that reads back as written and does not affect timekeeping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase clock enable |
| wr_en | input | 1 | Write strobe for the addressed location |
| addr | input | 4 | Register address |
| wdata | input | DATA_W | Write data; only bits [3:0] are used |
| rdata | output | DATA_W | Read data for `addr`, upper bits zero |
| pulse_16hz | output | 1 | Sixteenth-second step strobe |
| pulse_1hz | output | 1 | Second step strobe |

## Verification
The assertions assume that software loads only legal BCD values into the time bank, with seconds and minutes tens at most 5 and every ones digit at most 9. Under that assumption the digit-range property must hold through every carry. The stimulus keeps within this limit by building each clock setting from a legal calendar value, biased towards the last second of a minute, hour, day, month and year, and splitting it into digits. Random storage writes put arbitrary values in the upper data bits, since those bits are defined as ignored.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NIB_W     = 4;
    localparam int OVL_DEPTH = 13;
    localparam int ALM_DEPTH = 7;

    localparam logic [3:0] A_MODE   = 4'hD;
    localparam logic [3:0] A_TEST   = 4'hE;
    localparam logic [3:0] A_RESET  = 4'hF;
    localparam logic [3:0] A_ALM_LO = 4'h2;
    localparam logic [3:0] A_HFMT   = 4'hA;
    localparam logic [3:0] A_LEAP   = 4'hB;

    localparam int D_SEC1  = 0;
    localparam int D_SEC10 = 1;
    localparam int D_MIN1  = 2;
    localparam int D_MIN10 = 3;
    localparam int D_HR1   = 4;
    localparam int D_HR10  = 5;
    localparam int D_WDAY  = 6;
    localparam int D_DAY1  = 7;
    localparam int D_DAY10 = 8;
    localparam int D_MON1  = 9;
    localparam int D_MON10 = 10;
    localparam int D_YR1   = 11;
    localparam int D_YR10  = 12;

    typedef logic [NIB_W-1:0] nib_t;
    typedef nib_t [OVL_DEPTH-1:0] ovl_t;

    typedef enum logic [1:0] {
        BANK_TIME = 2'd0,
        BANK_CFG  = 2'd1,
        BANK_MEMA = 2'd2,
        BANK_MEMB = 2'd3
    } bank_e;

    typedef struct packed {
        logic  run;
        logic  alm_en;
        bank_e bank;
    } mode_t;

    typedef struct packed {
        ovl_t nxt;
        logic yr_step;
    } adv_t;

    // day 01, month 01, everything else zero
    localparam ovl_t TIME_INIT = 52'h0001010000000;

    function automatic logic [6:0] bcd2bin(nib_t hi, nib_t lo);
        return 7'(hi) * 7'd10 + 7'(lo);
    endfunction

    function automatic logic [7:0] bin2bcd(logic [6:0] v);
        logic [6:0] q;
        logic [6:0] r;
        q = v / 7'd10;
        r = v % 7'd10;
        return {q[3:0], r[3:0]};
    endfunction

    function automatic logic [6:0] month_len(logic [6:0] m, logic [1:0] phase);
        case (m)
            7'd2:                      return (phase == 2'd0) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction

    // One-second step of the whole calendar with ripple carry.
    function automatic adv_t tick_forward(ovl_t c, logic h24, logic [1:0] phase);
        adv_t       r;
        logic [6:0] v;
        logic [6:0] mlen;
        logic [7:0] bcd;
        logic       carry;
        logic       pm;
        r.nxt     = c;
        r.yr_step = 1'b0;

        v     = bcd2bin(c[D_SEC10], c[D_SEC1]);
        carry = (v >= 7'd59);
        v     = carry ? 7'd0 : v + 7'd1;
        bcd   = bin2bcd(v);
        r.nxt[D_SEC10] = bcd[7:4];
        r.nxt[D_SEC1]  = bcd[3:0];

        if (carry) begin
            v     = bcd2bin(c[D_MIN10], c[D_MIN1]);
            carry = (v >= 7'd59);
            v     = carry ? 7'd0 : v + 7'd1;
            bcd   = bin2bcd(v);
            r.nxt[D_MIN10] = bcd[7:4];
            r.nxt[D_MIN1]  = bcd[3:0];
        end

        if (carry) begin
            if (h24) begin
                v     = bcd2bin({2'b00, c[D_HR10][1:0]}, c[D_HR1]);
                carry = (v >= 7'd23);
                v     = carry ? 7'd0 : v + 7'd1;
                bcd   = bin2bcd(v);
                r.nxt[D_HR10] = bcd[7:4];
                r.nxt[D_HR1]  = bcd[3:0];
            end else begin
                v     = bcd2bin({3'b000, c[D_HR10][0]}, c[D_HR1]);
                pm    = c[D_HR10][1];
                carry = 1'b0;
                if (v == 7'd11) begin
                    v     = 7'd12;
                    carry = pm;
                    pm    = ~pm;
                end else if (v >= 7'd12) begin
                    v = 7'd1;
                end else begin
                    v = v + 7'd1;
                end
                bcd = bin2bcd(v);
                r.nxt[D_HR10] = {2'b00, pm, bcd[4]};
                r.nxt[D_HR1]  = bcd[3:0];
            end
        end

        if (carry) begin
            r.nxt[D_WDAY] = (c[D_WDAY] >= 4'd6) ? 4'd0 : c[D_WDAY] + 4'd1;
            mlen  = month_len(bcd2bin(c[D_MON10], c[D_MON1]), phase);
            v     = bcd2bin(c[D_DAY10], c[D_DAY1]);
            carry = (v >= mlen);
            v     = carry ? 7'd1 : v + 7'd1;
            bcd   = bin2bcd(v);
            r.nxt[D_DAY10] = bcd[7:4];
            r.nxt[D_DAY1]  = bcd[3:0];
        end

        if (carry) begin
            v     = bcd2bin(c[D_MON10], c[D_MON1]);
            carry = (v >= 7'd12);
            v     = carry ? 7'd1 : v + 7'd1;
            bcd   = bin2bcd(v);
            r.nxt[D_MON10] = bcd[7:4];
            r.nxt[D_MON1]  = bcd[3:0];
        end

        if (carry) begin
            v   = bcd2bin(c[D_YR10], c[D_YR1]);
            v   = (v >= 7'd99) ? 7'd0 : v + 7'd1;
            bcd = bin2bcd(v);
            r.nxt[D_YR10] = bcd[7:4];
            r.nxt[D_YR1]  = bcd[3:0];
            r.yr_step     = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider
    import rtc_pkg::*;
#(
    parameter int SUB_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic clr,
    output logic step16,
    output logic sec_step
);
    localparam int PW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;

    logic [PW-1:0] pre_q;
    logic [3:0]    six_q;
    logic          pre_end;

    assign pre_end  = (pre_q == PW'(SUB_DIV - 1));
    assign step16   = tick_en & ~clr & pre_end;
    assign sec_step = step16 & (six_q == 4'hF);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
            six_q <= '0;
        end else if (tick_en) begin
            if (pre_end) begin
                pre_q <= '0;
                six_q <= six_q + 4'd1;
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_step,
    input  logic       run,
    input  logic       clr_hold,
    input  logic       we,
    input  logic [3:0] waddr,
    input  nib_t       wnib,
    input  logic       h24,
    input  logic [1:0] phase,
    output ovl_t       time_q,
    output logic       yr_step
);
    logic hold_q;
    logic fire;
    adv_t adv;

    // a load in the same cycle defers the second by one cycle
    assign fire    = (sec_step | hold_q) & run & ~we;
    assign adv     = tick_forward(time_q, h24, phase);
    assign yr_step = fire & adv.yr_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= TIME_INIT;
            hold_q <= 1'b0;
        end else begin
            if (we) begin
                for (int i = 0; i < OVL_DEPTH; i++)
                    if (waddr == 4'(i)) time_q[i] <= wnib;
            end else if (fire) begin
                time_q <= adv.nxt;
            end

            if (clr_hold || fire) hold_q <= 1'b0;
            else if (sec_step)    hold_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rtc_nibble_ram.sv
module rtc_nibble_ram
    import rtc_pkg::*;
#(
    parameter  int N_BANKS = 2,
    parameter  int DEPTH   = 13,
    localparam int BW      = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [BW-1:0] bsel,
    input  logic [3:0]    addr,
    input  nib_t          wnib,
    output nib_t          rnib
);
    logic [N_BANKS-1:0][NIB_W-1:0] bank_rd;

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        nib_t cells [DEPTH];
        nib_t rd_g;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (we && bsel == BW'(g)) begin
                for (int i = 0; i < DEPTH; i++)
                    if (addr == 4'(i)) cells[i] <= wnib;
            end
        end

        always_comb begin
            rd_g = '0;
            for (int i = 0; i < DEPTH; i++)
                if (addr == 4'(i)) rd_g = cells[i];
        end

        assign bank_rd[g] = rd_g;
    end

    assign rnib = bank_rd[bsel];
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
    import rtc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SUB_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pulse_16hz,
    output logic              pulse_1hz
);
    localparam int MEM_BANKS = 2;

    nib_t       wnib;
    logic       in_ovl;
    mode_t      mode_q;
    nib_t       test_q;
    logic [1:0] pulse_en_q;   // [1]: 1 Hz, [0]: 16 Hz
    nib_t       alarm_q [ALM_DEPTH];
    logic       h24_q;
    logic [1:0] phase_q;

    logic time_we, cfg_we, mem_we, rst_we, clr_div, clr_alm;
    logic step16, sec_step, yr_step;
    ovl_t time_q;
    nib_t mem_rd, cfg_rd, rd_nib;

    assign wnib    = wdata[3:0];
    assign in_ovl  = (addr <= 4'd12);
    assign time_we = wr_en & in_ovl & (mode_q.bank == BANK_TIME);
    assign cfg_we  = wr_en & in_ovl & (mode_q.bank == BANK_CFG);
    assign mem_we  = wr_en & in_ovl & mode_q.bank[1];
    assign rst_we  = wr_en & (addr == A_RESET);
    assign clr_div = rst_we & wnib[1];
    assign clr_alm = rst_we & wnib[0];

    rtc_divider #(.SUB_DIV(SUB_DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .clr      (clr_div),
        .step16   (step16),
        .sec_step (sec_step)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .sec_step (sec_step),
        .run      (mode_q.run),
        .clr_hold (clr_div),
        .we       (time_we),
        .waddr    (addr),
        .wnib     (wnib),
        .h24      (h24_q),
        .phase    (phase_q),
        .time_q   (time_q),
        .yr_step  (yr_step)
    );

    rtc_nibble_ram #(.N_BANKS(MEM_BANKS), .DEPTH(OVL_DEPTH)) u_mem (
        .clk  (clk),
        .rst  (rst),
        .we   (mem_we),
        .bsel (mode_q.bank[0]),
        .addr (addr),
        .wnib (wnib),
        .rnib (mem_rd)
    );

    // control registers, fixed in every bank
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            test_q     <= '0;
            pulse_en_q <= '0;
        end else if (wr_en) begin
            if (addr == A_MODE) mode_q     <= mode_t'(wnib);
            if (addr == A_TEST) test_q     <= wnib;
            if (rst_we)         pulse_en_q <= wnib[3:2];
        end
    end

    // configuration bank
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ALM_DEPTH; i++) alarm_q[i] <= '0;
            h24_q   <= 1'b1;
            phase_q <= 2'd0;
        end else begin
            if (clr_alm) begin
                for (int i = 0; i < ALM_DEPTH; i++) alarm_q[i] <= '0;
            end else if (cfg_we) begin
                for (int i = 0; i < ALM_DEPTH; i++)
                    if (addr == A_ALM_LO + 4'(i)) alarm_q[i] <= wnib;
            end
            if (cfg_we && addr == A_HFMT) h24_q <= wnib[0];
            if (cfg_we && addr == A_LEAP) phase_q <= wnib[1:0];
            else if (yr_step)            phase_q <= phase_q + 2'd1;
        end
    end

    always_comb begin
        cfg_rd = '0;
        for (int i = 0; i < ALM_DEPTH; i++)
            if (addr == A_ALM_LO + 4'(i)) cfg_rd = alarm_q[i];
        if (addr == A_HFMT) cfg_rd = {3'b000, h24_q};
        if (addr == A_LEAP) cfg_rd = {2'b00, phase_q};
    end

    always_comb begin
        rd_nib = '0;
        case (addr)
            A_MODE:  rd_nib = nib_t'(mode_q);
            A_TEST:  rd_nib = test_q;
            A_RESET: rd_nib = {pulse_en_q, 2'b00};
            default: begin
                case (mode_q.bank)
                    BANK_TIME: begin
                        for (int i = 0; i < OVL_DEPTH; i++)
                            if (addr == 4'(i)) rd_nib = time_q[i];
                    end
                    BANK_CFG: rd_nib = cfg_rd;
                    default:  rd_nib = mem_rd;
                endcase
            end
        endcase
    end

    assign rdata      = DATA_W'(rd_nib);
    assign pulse_16hz = pulse_en_q[0] & step16;
    assign pulse_1hz  = pulse_en_q[1] & sec_step;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [3:0]        addr,
    input logic [DATA_W-1:0] rdata,
    input logic [3:0]        mode_q,
    input logic [51:0]       time_q,
    input logic              pulse_1hz
);
    a_r1_rdata_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rdata >> 4) == '0);

    a_r2_mode_write_only: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 4'hD) |=> $stable(mode_q));

    a_r9_frozen_time: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[3] && !(wr_en && addr <= 4'd12 && mode_q[1:0] == 2'd0))
        |=> $stable(time_q));

    a_r6_bcd_digit_range: assert property (@(posedge clk) disable iff (rst)
        time_q[3:0] <= 4'd9 && time_q[7:4] <= 4'd5 &&
        time_q[11:8] <= 4'd9 && time_q[15:12] <= 4'd5);

    a_r11_pulse_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse_1hz |=> !pulse_1hz);
endmodule

bind nibble_rtc rtc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .mode_q    (mode_q),
    .time_q    (time_q),
    .pulse_1hz (pulse_1hz)
);

// File: tb/tb_nibble_rtc.sv
module tb_nibble_rtc;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int SUB_DIV    = 2;
    localparam int TPS        = 16 * SUB_DIV;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              pulse_16hz, pulse_1hz;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int s, m, h, pm, dw, d, mo, y, lp;
        bit h24;
    } cal_t;

    nibble_rtc #(.DATA_W(DATA_W), .SUB_DIV(SUB_DIV)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pulse_16hz(pulse_16hz), .pulse_1hz(pulse_1hz)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int mdays(int mo, int lp);
        if (mo == 2) return (lp == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic cal_t step(cal_t c);
        cal_t n = c;
        bit nd = 0;
        n.s++;
        if (n.s == 60) begin
            n.s = 0; n.m++;
            if (n.m == 60) begin
                n.m = 0;
                if (n.h24) begin
                    n.h++;
                    if (n.h == 24) begin n.h = 0; nd = 1; end
                end else if (n.h == 11) begin
                    n.h = 12; nd = (n.pm == 1); n.pm = 1 - n.pm;
                end else if (n.h == 12) n.h = 1;
                else n.h++;
            end
        end
        if (nd) begin
            n.dw = (n.dw + 1) % 7;
            n.d++;
            if (n.d > mdays(n.mo, n.lp)) begin
                n.d = 1; n.mo++;
                if (n.mo == 13) begin
                    n.mo = 1; n.y = (n.y + 1) % 100; n.lp = (n.lp + 1) % 4;
                end
            end
        end
        return n;
    endfunction

    function automatic int digit(cal_t c, int i);
        case (i)
            0: return c.s % 10;   1: return c.s / 10;
            2: return c.m % 10;   3: return c.m / 10;
            4: return c.h % 10;
            5: return c.h24 ? c.h / 10 : c.pm * 2 + c.h / 10;
            6: return c.dw;
            7: return c.d % 10;   8: return c.d / 10;
            9: return c.mo % 10;  10: return c.mo / 10;
            11: return c.y % 10;  default: return c.y / 10;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1;
        v = int'(rdata[3:0]);
    endtask

    task automatic chk_rd(logic [3:0] a, int exp, string req);
        int v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_clock(cal_t c);
        wr(4'hD, 8'h1);
        wr(4'hA, 8'(c.h24));
        wr(4'hB, 8'(c.lp));
        wr(4'hD, 8'h0);
        for (int i = 0; i < 13; i++) wr(4'(i), 8'(digit(c, i)));
        wr(4'hF, 8'h2);
        wr(4'hD, 8'h8);
    endtask

    task automatic check_clock(cal_t e, string req);
        for (int i = 0; i < 13; i++) chk_rd(4'(i), digit(e, i), req);
        wr(4'hD, 8'h9);
        chk_rd(4'hB, e.lp, req);
        wr(4'hD, 8'h8);
    endtask

    task automatic one_step(cal_t c, string req);
        set_clock(c);
        ticks(TPS);
        check_clock(step(c), req);
    endtask

    function automatic cal_t mk(int h, int pm, int d, int mo, int y, int lp, bit h24);
        cal_t c;
        c.s = 59; c.m = 59; c.h = h; c.pm = pm; c.dw = 6; c.d = d;
        c.mo = mo; c.y = y; c.lp = lp; c.h24 = h24;
        return c;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, c16, c1;
        int unsigned seed;
        int rm [2][13];
        cal_t c;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 / R2 / R4 reset state
        chk_rd(4'hD, 0, "R2 mode reset");
        chk_rd(4'hE, 0, "R12 test reset");
        chk_rd(4'hF, 0, "R10 reset reg reset");
        c = mk(0, 0, 1, 1, 0, 0, 1); c.s = 0; c.m = 0; c.dw = 0;
        for (int i = 0; i < 13; i++) chk_rd(4'(i), digit(c, i), "R3 reset time");
        wr(4'hD, 8'h1);
        chk_rd(4'hA, 1, "R4 24h reset");
        chk_rd(4'hB, 0, "R4 leap reset");

        // R1 upper bits ignored / zero
        wr(4'hE, 8'hA5);
        rd(4'hE, v);
        check("R1 low nibble", v, 5);
        check("R1 upper rdata", int'(rdata[7:4]), 0);

        // R2 control registers visible in every bank
        for (int b = 0; b < 4; b++) begin
            wr(4'hD, 8'(b));
            chk_rd(4'hD, b, "R2 mode readback");
            chk_rd(4'hE, 5, "R2 test in bank");
            chk_rd(4'hF, 0, "R2 reset in bank");
        end

        // R4 configuration bank
        wr(4'hD, 8'h1);
        for (int i = 2; i <= 8; i++) wr(4'(i), 8'(i + 5));
        foreach (rm[, k]) begin end
        for (int i = 0; i < 13; i++) begin
            if (i < 2 || i == 9 || i == 12) wr(4'(i), 8'hF);
        end
        for (int i = 2; i <= 8; i++) chk_rd(4'(i), i + 5, "R4 alarm store");
        chk_rd(4'h0, 0, "R4 unused 0");
        chk_rd(4'h9, 0, "R4 unused 9");
        chk_rd(4'hC, 0, "R4 unused C");

        // R10 alarm clear
        wr(4'hF, 8'h1);
        for (int i = 2; i <= 8; i++) chk_rd(4'(i), 0, "R10 alarm clear");
        chk_rd(4'hA, 1, "R10 24h kept");
        chk_rd(4'hF, 0, "R10 action bits read 0");

        // R5 storage banks, random with model, upper data bits random (R1)
        for (int i = 0; i < 13; i++) begin
            rm[0][i] = 0; rm[1][i] = 0;
        end
        for (int k = 0; k < 60; k++) begin
            int b, a, d;
            b = int'($urandom % 2); a = int'($urandom % 13); d = int'($urandom % 16);
            wr(4'hD, 8'(2 + b));
            wr(4'(a), 8'(d + 16 * int'($urandom % 16)));
            rm[b][a] = d;
        end
        for (int b = 0; b < 2; b++) begin
            wr(4'hD, 8'(2 + b));
            for (int i = 0; i < 13; i++) chk_rd(4'(i), rm[b][i], "R5 storage bank");
        end

        // R6 / R7 / R8 directed carries
        one_step(mk(23, 0, 31, 12, 99, 3, 1), "R6 R7 year wrap");
        one_step(mk(23, 0, 28, 2, 21, 1, 1), "R7 feb 28");
        one_step(mk(23, 0, 28, 2, 24, 0, 1), "R7 feb 29 leap");
        one_step(mk(23, 0, 29, 2, 24, 0, 1), "R7 feb 29 end");
        one_step(mk(23, 0, 30, 4, 10, 2, 1), "R7 april 30");
        one_step(mk(23, 0, 30, 5, 10, 2, 1), "R7 may 30");
        one_step(mk(11, 1, 15, 6, 33, 1, 0), "R8 11pm to 12am");
        one_step(mk(11, 0, 15, 6, 33, 1, 0), "R8 11am to 12pm");
        one_step(mk(12, 1, 15, 6, 33, 1, 0), "R8 12 to 1");
        one_step(mk(9, 0, 7, 3, 45, 2, 1), "R6 hour carry");

        // R9 freeze with a single held second
        c = mk(10, 0, 5, 5, 50, 1, 1); c.s = 30; c.m = 20;
        set_clock(c);
        wr(4'hD, 8'h0);
        ticks(TPS);
        chk_rd(4'h0, 0, "R9 frozen sec ones");
        ticks(TPS);
        chk_rd(4'h0, 0, "R9 still frozen");
        wr(4'hD, 8'h8);
        chk_rd(4'h0, 1, "R9 one held second");
        chk_rd(4'h1, 3, "R9 sec tens");

        // R10 divider restart
        set_clock(c);
        ticks(20);
        wr(4'hF, 8'h2);
        ticks(TPS - 1);
        chk_rd(4'h0, 0, "R10 divider restarted");
        ticks(1);
        chk_rd(4'h0, 1, "R10 full second");

        // R11 pulses enabled, then disabled
        wr(4'hF, 8'hE);
        chk_rd(4'hF, 12, "R10 pulse bits stored");
        for (int pass = 0; pass < 2; pass++) begin
            c16 = 0; c1 = 0;
            @(negedge clk);
            tick_en = 1'b1;
            for (int i = 0; i < 2 * TPS; i++) begin
                #1;
                c16 += int'(pulse_16hz);
                c1  += int'(pulse_1hz);
                @(negedge clk);
            end
            tick_en = 1'b0;
            check("R11 16hz count", c16, pass == 0 ? 2 * TPS / SUB_DIV : 0);
            check("R11 1hz count", c1, pass == 0 ? 2 : 0);
            wr(4'hF, 8'h2);
        end

        // R12 test nibble has no effect on counting
        wr(4'hE, 8'h9);
        one_step(mk(4, 0, 12, 8, 61, 3, 1), "R12 timekeeping with test set");
        chk_rd(4'hE, 9, "R12 test readback");

        // random calendars biased towards boundaries (R6 R7 R8)
        for (int k = 0; k < 30; k++) begin
            c.h24 = bit'($urandom % 2);
            c.s  = ($urandom % 2) ? 59 : int'($urandom % 60);
            c.m  = ($urandom % 2) ? 59 : int'($urandom % 60);
            c.pm = int'($urandom % 2);
            if (c.h24) c.h = ($urandom % 2) ? 23 : int'($urandom % 24);
            else       c.h = ($urandom % 2) ? 11 + int'($urandom % 2) : 1 + int'($urandom % 12);
            c.mo = ($urandom % 3 == 0) ? 12 : 1 + int'($urandom % 12);
            c.lp = int'($urandom % 4);
            c.d  = ($urandom % 2) ? mdays(c.mo, c.lp) : 1 + int'($urandom % mdays(c.mo, c.lp));
            c.dw = int'($urandom % 7);
            c.y  = ($urandom % 3 == 0) ? 99 : int'($urandom % 100);
            one_step(c, "R6 R7 R8 random step");
        end

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule